// File: doc/BRIEF.md
# Signed Byte to Compact Floating-Point Converter

This block turns a signed two's-complement integer, 8 bits wide by default, into a 12-bit floating-point word. The word holds a sign, a 5-bit exponent stored with an offset of 15, and a 6-bit fraction. The fraction keeps its leading one explicitly, so a nonzero value reads as 0.1xxxxx × 2^e. The input and the output each carry a valid strobe. Conversion runs in a fixed three-stage pipeline. The first stage takes sign and magnitude, the second finds the highest set bit, and the third shifts the magnitude, adds the offset and packs the word.

A new integer can be presented on every clock. Each result appears three cycles after its input. Magnitudes with more significant bits than the fraction can hold lose their low bits without rounding. A zero input produces an all-zero word.

Top module: `int_to_float12`

## Requirements
- R1: The output word is laid out with the sign at bit 11, the exponent in bits 10:6 and the fraction in bits 5:0.
- R2: For a nonzero magnitude m with 2^(e-1) <= m < 2^e, the stored exponent is e + 15. For example, 1 gives 10000 and 7 gives 10010, so 7 encodes as 0x4B8.
- R3: For every nonzero input, fraction bit 5 (the first bit after the radix point) is 1.
- R4: A negative input sets the sign bit to 1 and encodes the magnitude that results from inverting the bits and adding one. For example, -7 encodes as 0xCB8.
- R5: An input of 0 produces the word 0x000.
- R6: When the magnitude has more than 6 significant bits, the bits below the top six are dropped with no rounding. For example, 127 encodes as 0x5BF and 65 encodes as 0x5A0.
- R7: The input -128 is converted using a magnitude of 128 and encodes as 0xDE0.
- R8: out_valid is high exactly three clock cycles after in_valid was high. An input whose in_valid is low produces no out_valid.
- R9: Inputs presented on consecutive cycles are all converted, each result appearing in order on consecutive cycles.
- R10: While rst is high and in the cycle after it is released, out_valid is 0 and out_word is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_int |
| in_int | input | 8 | Signed two's-complement integer |
| out_valid | output | 1 | Qualifies out_word |
| out_word | output | 12 | Sign, biased exponent, fraction with explicit leading one |

## Verification
Named values are checked against hand-computed words. The value 1 probes the smallest exponent, 7 is the worked example, 127 and 65 show truncation rather than rounding, and -128 tests the one magnitude that does not fit in the positive range. A back-to-back sweep then feeds all 256 inputs on consecutive cycles and compares each result against an arithmetic model. That model finds the exponent by counting powers of two and the fraction by scaling, which separates shift-amount errors from exponent-offset errors and from ordering slips. A separate sparse pattern with idle cycles confirms that invalid inputs produce no output.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int DEF_IN_W   = 8;
    localparam int DEF_EXP_W  = 5;
    localparam int DEF_FRAC_W = 6;
    localparam int DEF_BIAS   = 15;
endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude #(
    parameter int IN_W = i2f_pkg::DEF_IN_W
) (
    input  logic [IN_W-1:0] value,
    output logic            sgn,
    output logic [IN_W-1:0] mag
);
    // Two's-complement negation; the most negative value maps onto itself,
    // which read as unsigned is exactly its magnitude.
    always_comb begin
        sgn = value[IN_W-1];
        mag = sgn ? (~value + 1'b1) : value;
    end
endmodule

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
    parameter int IN_W  = i2f_pkg::DEF_IN_W,
    localparam int POS_W = (IN_W > 1) ? $clog2(IN_W) : 1
) (
    input  logic [IN_W-1:0]  mag,
    output logic             nz,
    output logic [POS_W-1:0] pos
);
    // Ascending scan: the last hit is the highest set bit.
    always_comb begin
        nz  = 1'b0;
        pos = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (mag[i]) begin
                nz  = 1'b1;
                pos = POS_W'(i);
            end
        end
    end
endmodule

// File: rtl/i2f_pack.sv
module i2f_pack #(
    parameter int IN_W   = i2f_pkg::DEF_IN_W,
    parameter int EXP_W  = i2f_pkg::DEF_EXP_W,
    parameter int FRAC_W = i2f_pkg::DEF_FRAC_W,
    parameter int BIAS   = i2f_pkg::DEF_BIAS,
    localparam int POS_W  = (IN_W > 1) ? $clog2(IN_W) : 1,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              sgn,
    input  logic              nz,
    input  logic [POS_W-1:0]  pos,
    input  logic [IN_W-1:0]   mag,
    output logic [WORD_W-1:0] word
);
    logic [POS_W-1:0]  shamt;
    logic [IN_W-1:0]   norm;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  expo;

    always_comb begin
        shamt = POS_W'(IN_W - 1) - pos;
        norm  = mag << shamt;
        // Leading one at bit pos means the value is 0.1... x 2^(pos+1).
        expo  = EXP_W'(pos) + EXP_W'(BIAS + 1);
    end

    generate
        if (FRAC_W <= IN_W) begin : g_trunc
            assign frac = FRAC_W'(norm >> (IN_W - FRAC_W));
        end else begin : g_pad
            assign frac = {norm, {(FRAC_W - IN_W){1'b0}}};
        end
    endgenerate

    always_comb word = nz ? {sgn, expo, frac} : '0;
endmodule

// File: rtl/int_to_float12.sv
module int_to_float12 #(
    parameter int IN_W   = i2f_pkg::DEF_IN_W,
    parameter int EXP_W  = i2f_pkg::DEF_EXP_W,
    parameter int FRAC_W = i2f_pkg::DEF_FRAC_W,
    parameter int BIAS   = i2f_pkg::DEF_BIAS,
    localparam int POS_W  = (IN_W > 1) ? $clog2(IN_W) : 1,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_int,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic            vld;
        logic            sgn;
        logic [IN_W-1:0] mag;
    } st1_t;

    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic             nz;
        logic [POS_W-1:0] pos;
        logic [IN_W-1:0]  mag;
    } st2_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              m_sgn;
    logic [IN_W-1:0]   m_mag;
    logic              l_nz;
    logic [POS_W-1:0]  l_pos;
    logic [WORD_W-1:0] p_word;

    i2f_magnitude #(.IN_W(IN_W)) u_mag (
        .value (in_int),
        .sgn   (m_sgn),
        .mag   (m_mag)
    );

    i2f_lead_one #(.IN_W(IN_W)) u_lod (
        .mag (pipe_q.s1.mag),
        .nz  (l_nz),
        .pos (l_pos)
    );

    i2f_pack #(.IN_W(IN_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_pack (
        .sgn  (pipe_q.s2.sgn),
        .nz   (pipe_q.s2.nz),
        .pos  (pipe_q.s2.pos),
        .mag  (pipe_q.s2.mag),
        .word (p_word)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1.vld = in_valid;
        pipe_d.s1.sgn = m_sgn;
        pipe_d.s1.mag = m_mag;
        pipe_d.s2.vld = pipe_q.s1.vld;
        pipe_d.s2.sgn = pipe_q.s1.sgn;
        pipe_d.s2.nz  = l_nz;
        pipe_d.s2.pos = l_pos;
        pipe_d.s2.mag = pipe_q.s1.mag;
        pipe_d.s3.vld = pipe_q.s2.vld;
        pipe_d.s3.word = p_word;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3.vld;
    assign out_word  = pipe_q.s3.word;

    localparam int EXP_LSB = FRAC_W;
    localparam int EXP_MSB = FRAC_W + EXP_W - 1;

    // Valid walks one stage per cycle into the output register.
    assert_valid_step_R8: assert property (@(posedge clk) disable iff (rst)
        pipe_q.s2.vld |=> out_valid)
        else $error("valid lost between stage 2 and output");

    assert_lead_frac_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[EXP_MSB:EXP_LSB] != '0) |-> out_word[FRAC_W-1])
        else $error("nonzero result not normalized");

    assert_zero_word_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[EXP_MSB:EXP_LSB] == '0) |-> (out_word == '0))
        else $error("zero exponent with stray bits");

    assert_exp_range_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[EXP_MSB:EXP_LSB] != '0) |->
        (int'(out_word[EXP_MSB:EXP_LSB]) >= BIAS + 1 &&
         int'(out_word[EXP_MSB:EXP_LSB]) <= BIAS + IN_W))
        else $error("exponent outside the reachable range");

    assert_sign_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[WORD_W-1]) |-> (out_word[EXP_MSB:EXP_LSB] != '0))
        else $error("negative sign on a zero word");
endmodule

// File: tb/int_to_float12_test.sv
`timescale 1ns/1ps
module int_to_float12_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_int = '0;
    logic        out_valid;
    logic [11:0] out_word;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    int_to_float12 uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_int(in_int),
        .out_valid(out_valid), .out_word(out_word)
    );

    // Independent model: count powers of two for the exponent, scale for the fraction.
    function automatic logic [11:0] model(input int v);
        int m;
        int e;
        int f;
        logic s;
        s = (v < 0);
        m = s ? -v : v;
        if (m == 0) return 12'h000;
        e = 0;
        while ((1 << e) <= m) e++;
        f = (m * 64) >> e;
        return {s, 5'(e + 15), 6'(f)};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp_v);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 valid in reset", {11'b0, out_valid}, 12'h000);
        check("R10 word in reset", out_word, 12'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R10 valid after release", {11'b0, out_valid}, 12'h000);
        check("R10 word after release", out_word, 12'h000);
    endtask

    task automatic t_single(input string req, input int v, input logic [11:0] exp_v);
        @(negedge clk);
        in_int   = 8'(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check({req, " R8 valid"}, {11'b0, out_valid}, 12'h001);
        check(req, out_word, exp_v);
        @(negedge clk);
        check({req, " R8 single pulse"}, {11'b0, out_valid}, 12'h000);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 256 + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check("R9 stream valid", {11'b0, out_valid}, 12'h001);
                check("R9 stream word R2 R6", out_word, model(i - 3 - 128));
            end
            if (i < 256) begin
                in_int   = 8'(i - 128);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R8 stream drained", {11'b0, out_valid}, 12'h000);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 3)
                check("R8 gap valid", {11'b0, out_valid}, {11'b0, ((i - 3) % 3) == 0});
            in_valid = (i % 3) == 0;
            in_int   = 8'(i * 7 - 40);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single("R2 one", 1, 12'h420);
        t_single("R2 R1 seven", 7, 12'h4B8);
        t_single("R4 minus seven", -7, 12'hCB8);
        t_single("R5 zero", 0, 12'h000);
        t_single("R6 R3 max positive", 127, 12'h5BF);
        t_single("R6 truncate", 65, 12'h5A0);
        t_single("R7 most negative", -128, 12'hDE0);
        t_stream();
        t_gaps();
        repeat (4) @(negedge clk);
        check("R8 idle", {11'b0, out_valid}, 12'h000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule